// File: doc/BRIEF.md
# Enable-Coded ALU Slice Array

This block is a combinational arithmetic and logic unit for a word of `WIDTH` bits. It is made from identical one-bit slices joined by a ripple carry chain. Every slice computes its result bit as a sum of products. Four enable pins switch groups of product terms on or off, so a single slice structure provides five operations.

The first pin complements the B operand before it enters the slice. The second pin lets the carry pass into each slice. The third pin switches on the four product terms that form the three-input parity of A, the effective B and the carry. The fourth pin adds one extra product, A AND effective B. The result bit is the OR of all product terms that are switched on. OR is produced by switching on both the parity terms and the AND term with the carry disabled, because the two sets of terms together cover every case where either operand bit is 1.

The enable pins are read as the nibble {invert-B, carry-enable, parity-enable, and-enable}, most significant first. Any value outside the five listed below is a don't-care.

Top module: `aluSliceArray`

## Requirements
- R1: With enables 0110 (add), {carryOut, result} equals opA + opB + carryIn as an unsigned (WIDTH+1)-bit sum.
- R2: With enables 1110 (subtract), {carryOut, result} equals opA + ~opB + carryIn. With carryIn = 1 the result is opA − opB modulo 2^WIDTH, and carryOut is 1 exactly when opA ≥ opB (no borrow).
- R3: With enables 0010, result equals opA XOR opB.
- R4: With enables 0011, result equals opA OR opB.
- R5: With enables 0001, result equals opA AND opB.
- R6: Whenever the carry-enable pin is 0, carryOut is 0 and carryIn has no effect on result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0; set it to 1 for subtraction |
| ctlInvB | input | 1 | Complement opB before it enters the slices |
| ctlCarryEn | input | 1 | Let the carry pass into each slice and out of the word |
| ctlXorEn | input | 1 | Switch on the four parity product terms |
| ctlAndEn | input | 1 | Switch on the A AND effective-B product term |
| result | output | WIDTH | Result word |
| carryOut | output | 1 | Carry out of the top slice; 0 when the carry is disabled |

## Verification
The assertions assume that the enable pins hold one of the five listed encodings whenever a result is checked. Each assertion is qualified by its own encoding, except the carry-disable assertion, which holds for any value with the carry-enable pin low. The stimulus drives only the five encodings. For each one it sweeps every pair of 4-bit operands with both carry-in values, so the logic operations are seen with carry-in at 1 as well as at 0.

// File: rtl/aluPkg.sv
package aluPkg;
  // Enable strobes passed from the control decode to the slice datapath
  typedef struct packed {
    logic invB;     // complement B operand
    logic carryEn;  // gate carry into slices and out of the word
    logic xorEn;    // parity minterm group
    logic andEn;    // extra A & B' product
  } aluStrobes_t;
endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic        ctlInvB,
  input  logic        ctlCarryEn,
  input  logic        ctlXorEn,
  input  logic        ctlAndEn,
  output aluStrobes_t strobes
);
  always_comb begin
    strobes.invB    = ctlInvB;
    strobes.carryEn = ctlCarryEn;
    strobes.xorEn   = ctlXorEn;
    strobes.andEn   = ctlAndEn;
  end
endmodule

// File: rtl/aluSlice.sv
module aluSlice
  import aluPkg::*;
(
  input  logic        a,
  input  logic        b,
  input  logic        cIn,
  input  aluStrobes_t st,
  output logic        s,
  output logic        cOut
);
  logic bEff, cGated;
  logic mOnlyC, mOnlyB, mOnlyA, mAll;
  logic parityTerm, andTerm;

  always_comb begin
    bEff   = b ^ st.invB;
    cGated = cIn & st.carryEn;
    // minterms of the three-input parity, one per odd input pattern
    mOnlyC = ~a & ~bEff &  cGated;
    mOnlyB = ~a &  bEff & ~cGated;
    mOnlyA =  a & ~bEff & ~cGated;
    mAll   =  a &  bEff &  cGated;
    parityTerm = st.xorEn & (mOnlyC | mOnlyB | mOnlyA | mAll);
    andTerm    = st.andEn & a & bEff;
    s    = parityTerm | andTerm;
    cOut = st.carryEn & ((a & bEff) | (a & cGated) | (bEff & cGated));
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);
  localparam int CHAIN_LEN = WIDTH + 1;

  logic [CHAIN_LEN-1:0] carryChain;

  assign carryChain[0] = carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    aluSlice u_slice (
      .a    (opA[i]),
      .b    (opB[i]),
      .cIn  (carryChain[i]),
      .st   (strobes),
      .s    (result[i]),
      .cOut (carryChain[i+1])
    );
  end

  assign carryOut = carryChain[CHAIN_LEN-1];
endmodule

// File: rtl/aluSliceArray.sv
module aluSliceArray
  import aluPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic             ctlInvB,
  input  logic             ctlCarryEn,
  input  logic             ctlXorEn,
  input  logic             ctlAndEn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);
  aluStrobes_t strobes;

  aluCtrl u_ctrl (
    .ctlInvB    (ctlInvB),
    .ctlCarryEn (ctlCarryEn),
    .ctlXorEn   (ctlXorEn),
    .ctlAndEn   (ctlAndEn),
    .strobes    (strobes)
  );

  aluDatapath #(.WIDTH(WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .strobes  (strobes),
    .result   (result),
    .carryOut (carryOut)
  );
endmodule

// File: rtl/aluSliceArrayChk.sv
module aluSliceArrayChk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic             ctlInvB,
  input logic             ctlCarryEn,
  input logic             ctlXorEn,
  input logic             ctlAndEn,
  input logic [WIDTH-1:0] result,
  input logic             carryOut
);
  logic [3:0]     mode;
  logic [WIDTH:0] addRef, subRef;

  always_comb begin
    mode   = {ctlInvB, ctlCarryEn, ctlXorEn, ctlAndEn};
    addRef = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
    subRef = {1'b0, opA} + {1'b0, ~opB} + {{WIDTH{1'b0}}, carryIn};
  end

  always_comb begin
    if (mode == 4'b0110) p_add_r1: assert ({carryOut, result} == addRef);
    if (mode == 4'b1110) p_sub_r2: assert ({carryOut, result} == subRef);
    if (mode == 4'b0010) p_xor_r3: assert (result == (opA ^ opB));
    if (mode == 4'b0011) p_or_r4:  assert (result == (opA | opB));
    if (mode == 4'b0001) p_and_r5: assert (result == (opA & opB));
    if (!ctlCarryEn)     p_carry_off_r6: assert (carryOut == 1'b0);
  end
endmodule

bind aluSliceArray aluSliceArrayChk #(.WIDTH(WIDTH)) u_chk (
  .opA        (opA),
  .opB        (opB),
  .carryIn    (carryIn),
  .ctlInvB    (ctlInvB),
  .ctlCarryEn (ctlCarryEn),
  .ctlXorEn   (ctlXorEn),
  .ctlAndEn   (ctlAndEn),
  .result     (result),
  .carryOut   (carryOut)
);

// File: tb/test_aluSliceArray.sv
module test_aluSliceArray;
  localparam int WIDTH = 4;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;
  localparam int NUM_VALS = 1 << WIDTH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [WIDTH-1:0] opA = '0, opB = '0;
  logic carryIn = 1'b0;
  logic ctlInvB = 1'b0, ctlCarryEn = 1'b0, ctlXorEn = 1'b0, ctlAndEn = 1'b0;
  logic [WIDTH-1:0] result;
  logic carryOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aluSliceArray #(.WIDTH(WIDTH)) i_aluSliceArray (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .ctlInvB(ctlInvB), .ctlCarryEn(ctlCarryEn),
    .ctlXorEn(ctlXorEn), .ctlAndEn(ctlAndEn),
    .result(result), .carryOut(carryOut)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s opA=%0d opB=%0d cin=%0b mode=%b: actual=%0d expected=%0d",
               req, opA, opB, carryIn,
               {ctlInvB, ctlCarryEn, ctlXorEn, ctlAndEn}, actual, expected);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // enables all 0: carry disabled, no terms on
    check("R6 reset carry", int'(carryOut), 0);
    check("R6 reset result", int'(result), 0);

    for (int m = 0; m < 5; m++) begin
      logic [3:0] enc;
      string tag;
      case (m)
        0: begin enc = 4'b0110; tag = "R1 add"; end
        1: begin enc = 4'b1110; tag = "R2 sub"; end
        2: begin enc = 4'b0010; tag = "R3 xor"; end
        3: begin enc = 4'b0011; tag = "R4 or"; end
        default: begin enc = 4'b0001; tag = "R5 and"; end
      endcase
      for (int a = 0; a < NUM_VALS; a++) begin
        for (int b = 0; b < NUM_VALS; b++) begin
          for (int c = 0; c < 2; c++) begin
            int expRes, expCout, full;
            @(negedge clk);
            opA = WIDTH'(a);
            opB = WIDTH'(b);
            carryIn = c[0];
            {ctlInvB, ctlCarryEn, ctlXorEn, ctlAndEn} = enc;
            case (m)
              0: full = a + b + c;
              1: full = a + ((NUM_VALS - 1) - b) + c;
              2: full = a ^ b;
              3: full = a | b;
              default: full = a & b;
            endcase
            expRes  = full % NUM_VALS;
            expCout = (m < 2) ? (full / NUM_VALS) : 0;
            #2;
            check(tag, int'(result), expRes);
            if (m < 2) check(tag, int'(carryOut), expCout);
            else check("R6 carry off", int'(carryOut), 0);
            if (m == 1 && c == 1) begin
              check("R2 difference", int'(result), (a - b + NUM_VALS) % NUM_VALS);
              check("R2 no-borrow", int'(carryOut), (a >= b) ? 1 : 0);
            end
          end
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule